// File: doc/BRIEF.md
# Video Sync Word Normalizer

This block sits on a parallel video word path and runs on the word clock. It examines every accepted word for the timing-reference codes that mark line and field boundaries. When all of the upper bits of a word are zero, or all of them are one, the word is treated as a reserved code. The block then overwrites the low bits so that they match the upper bits. Eight-bit sources often leave the two extra bits undefined, and this step turns their sync words into clean ten-bit codes. Every other word passes through unchanged.

A bypass input switches normalization off for streams that are not video. With bypass set, every word goes through exactly as received and no sync is reported. The result is registered, so it appears one clock after the input, together with a matching valid flag and a one-cycle sync flag.

Top module: `sync_word_normalizer`

## Requirements
- R1: While `rst` is high at a rising edge, `out_word`, `out_valid` and `out_sync` are all zero after that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge.
- R3: A word accepted with `in_valid`=1 and `bypass`=0 whose bits 9..2 are all zero appears one cycle later with bits 9..2 unchanged and bits 1..0 forced to 00. This covers input codes 0x000 to 0x003.
- R4: A word accepted with `in_valid`=1 and `bypass`=0 whose bits 9..2 are all one appears one cycle later with bits 9..2 unchanged and bits 1..0 forced to 11. This covers input codes 0x3FC to 0x3FF.
- R5: An accepted word whose bits 9..2 are neither all zero nor all one appears one cycle later with all ten bits unchanged.
- R6: When a word is accepted with `bypass`=1, it appears one cycle later with all ten bits unchanged, including reserved codes, and `out_sync` is 0.
- R7: `out_sync` is 1 in exactly the cycle after a word that is accepted with `bypass`=0 and falls into the all-zero or all-one class. It is 0 in every other cycle.
- R8: When `in_valid` is 0 at an edge, `out_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 10 | Incoming parallel word |
| in_valid | input | 1 | Input word strobe |
| bypass | input | 1 | When high, words pass through unaltered |
| out_word | output | 10 | Normalized word, one cycle after input |
| out_valid | output | 1 | Strobe aligned with out_word |
| out_sync | output | 1 | One-cycle flag for a reserved code that was seen |

## Verification
The assertions assume that `in_valid`, `bypass` and `in_word` are stable across each rising edge and never unknown after reset. They also assume that reset lasts at least one edge before the first accepted word. The bench drives every input on the falling edge and holds reset for several edges. It then sweeps all 1024 word values with bypass both off and on, inserting idle cycles between words so that the hold behaviour and the flag deassertion are exercised under legal stimulus.

// File: rtl/snw_pkg.sv
package snw_pkg;

    // Classification of a word by its upper bits
    typedef enum logic [1:0] {
        SNW_PLAIN = 2'd0,
        SNW_LOW   = 2'd1,
        SNW_HIGH  = 2'd2
    } snw_class_e;

endpackage

// File: rtl/snw_detect.sv
module snw_detect
    import snw_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] hi_bits,
    output snw_class_e      word_class
);

    logic all_zero;
    logic all_one;

    always_comb begin
        all_zero = (hi_bits == '0);
        all_one  = (hi_bits == '1);
        if (all_zero) begin
            word_class = SNW_LOW;
        end else if (all_one) begin
            word_class = SNW_HIGH;
        end else begin
            word_class = SNW_PLAIN;
        end
    end

endmodule

// File: rtl/snw_patch.sv
module snw_patch
    import snw_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic [DATA_W-1:0] word_in,
    input  snw_class_e        word_class,
    input  logic              bypass,
    output logic [DATA_W-1:0] word_out
);

    localparam int HI_W = DATA_W - LOW_W;

    logic force_en;
    logic force_val;

    always_comb begin
        force_en  = !bypass && (word_class != SNW_PLAIN);
        force_val = (word_class == SNW_HIGH);
    end

    assign word_out[DATA_W-1:LOW_W] = word_in[DATA_W-1:LOW_W];

    for (genvar b = 0; b < LOW_W; b++) begin : g_low
        assign word_out[b] = force_en ? force_val : word_in[b];
    end

    logic unused_hi;
    assign unused_hi = ^word_in[DATA_W-1:DATA_W-HI_W] & 1'b0;

endmodule

// File: rtl/sync_word_normalizer.sv
module sync_word_normalizer
    import snw_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_valid,
    input  logic              bypass,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_sync
);

    localparam int HI_W = DATA_W - LOW_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              valid;
        logic              sync;
    } snw_state_t;

    snw_state_t        st_d;
    snw_state_t        st_q;
    snw_class_e        cls;
    logic [DATA_W-1:0] patched;

    snw_detect #(
        .HI_W (HI_W)
    ) u_detect (
        .hi_bits    (in_word[DATA_W-1:LOW_W]),
        .word_class (cls)
    );

    snw_patch #(
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W)
    ) u_patch (
        .word_in    (in_word),
        .word_class (cls),
        .bypass     (bypass),
        .word_out   (patched)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.sync  = in_valid && !bypass && (cls != SNW_PLAIN);
        if (in_valid) begin
            st_d.word = patched;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word  = st_q.word;
    assign out_valid = st_q.valid;
    assign out_sync  = st_q.sync;

endmodule

// File: rtl/snw_checker.sv
module snw_checker #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] in_word,
    input logic              in_valid,
    input logic              bypass,
    input logic [DATA_W-1:0] out_word,
    input logic              out_valid,
    input logic              out_sync
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_word == '0 && !out_valid && !out_sync));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R3
    low_force_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(bypass)
         && $past(in_word[DATA_W-1:LOW_W]) == '0)
        |-> (out_word == '0));

    // R4
    high_force_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(bypass)
         && $past(in_word[DATA_W-1:LOW_W]) == '1)
        |-> (out_word == '1));

    // R6
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(bypass))
        |-> (out_word == $past(in_word) && !out_sync));

    // R7
    sync_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_valid);

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_word));

endmodule

bind sync_word_normalizer snw_checker #(
    .DATA_W (DATA_W),
    .LOW_W  (LOW_W)
) u_snw_checker (
    .clk       (clk),
    .rst       (rst),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .out_word  (out_word),
    .out_valid (out_valid),
    .out_sync  (out_sync)
);

// File: tb/sync_word_normalizer_tb.sv
module sync_word_normalizer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] in_word;
    logic       in_valid;
    logic       bypass;
    logic [9:0] out_word;
    logic       out_valid;
    logic       out_sync;

    int checks   = 0;
    int failures = 0;
    logic [9:0] exp_word;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_word_normalizer u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .bypass    (bypass),
        .out_word  (out_word),
        .out_valid (out_valid),
        .out_sync  (out_sync)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on falling edge, sample shortly after the next rising edge
    task automatic step(input logic [9:0] w, input logic v, input logic off);
        logic       reserved;
        logic [9:0] nw;
        @(negedge clk);
        in_word  = w;
        in_valid = v;
        bypass   = off;
        reserved = (w[9:2] == 8'h00) || (w[9:2] == 8'hFF);
        nw = w;
        if (!off && w[9:2] == 8'h00) nw = {w[9:2], 2'b00};
        if (!off && w[9:2] == 8'hFF) nw = {w[9:2], 2'b11};
        if (v) exp_word = nw;
        @(posedge clk);
        #1;
        check("R2", {9'd0, out_valid}, {9'd0, v});
        check("R7", {9'd0, out_sync}, {9'd0, v && !off && reserved});
        if (!v)
            check("R8", out_word, exp_word);
        else if (off)
            check("R6", out_word, exp_word);
        else if (w[9:2] == 8'h00)
            check("R3", out_word, exp_word);
        else if (w[9:2] == 8'hFF)
            check("R4", out_word, exp_word);
        else
            check("R5", out_word, exp_word);
    endtask

    initial begin
        rst = 1'b1;
        in_word = 10'h3A5;
        in_valid = 1'b1;
        bypass = 1'b0;
        exp_word = '0;
        repeat (4) @(posedge clk);
        #1;
        // R1
        check("R1", out_word, 10'h000);
        check("R1", {9'd0, out_valid}, 10'd0);
        check("R1", {9'd0, out_sync}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        for (int off = 0; off < 2; off++) begin
            for (int w = 0; w < 1024; w++) begin
                step(w[9:0], 1'b1, off[0]);
                if ((w % 7) == 3) step(~w[9:0], 1'b0, off[0]);
            end
        end
        // idle with reserved pattern: nothing changes
        step(10'h3FD, 1'b1, 1'b0);
        step(10'h001, 1'b0, 1'b0);
        step(10'h002, 1'b1, 1'b0);
        step(10'h3FE, 1'b1, 1'b1);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule